// File: doc/BRIEF.md
# Text-Mode Pixel Renderer

The block turns a stream of active-area pixel coordinates into RGB pixels for a fixed page of text. The page is a grid of 40 columns by 30 rows of 16x16 cells, which fills 640x480. A timing generator upstream supplies the coordinates and a display-enable flag. This block produces no sync of its own.

Each 8-pixel slice of a glyph row is fetched one slice ahead of its use. Two chained synchronous ROM reads do the fetch: the text page gives a character code, and the glyph store gives one byte of that character's row. The two reads sit in the last two clocks of the slice before the one being shown. The byte is then shown one bit per clock, most significant bit first. A pattern-select input swaps the text for colour bars taken from the x coordinate. Outside the active area the output is black.

Both ROMs are computed from content functions in the shared package, so the page and the font are fixed at build time.

Top module: `text_pixel_renderer`

## Requirements
- R1: While `rst_ni` is low, `rgb_o` is 0, and the glyph byte register and memory enables are cleared. The first eight pixels shown after reset, before any fetch has completed, are therefore black even with display enable high.
- R2: The character shown at pixel (x,y) is read from text address row*40+col. Here col = x[9:4] and row = y[9:4].
- R3: The glyph byte used is at glyph address code*32 + y[3:0]*2 + x[3]. The byte with x[3]=0 is the left half of the 16-pixel row.
- R4: Within a slice, pixel x[2:0]=0 shows bit 7 of the byte and x[2:0]=7 shows bit 0. One new byte is loaded every 8 pixels.
- R5: The fetch issued at x[2:0]=6 targets the slice that starts at x+2. The enables are asserted from that edge and released at the next x[2:0]=0. When x+2 reaches 640, the fetch targets column 0 of line y+1, and line 479 wraps to line 0.
- R6: `rgb_o` shows the pixel for the coordinate presented one clock edge earlier.
- R7: In text mode all three channels carry the same glyph bit: 3'b111 for a set bit, 3'b000 for a clear bit.
- R8: With `pattern_i` high and display enable high, `rgb_o` = x[7:5] as {red, green, blue}.
- R9: With `de_i` low, `rgb_o` is 3'b000 whatever the pattern select or glyph data. The fetch pipeline keeps running, so the next line still shows the correct glyphs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_x_i | input | 10 | Current pixel column, 0..639 |
| pix_y_i | input | 10 | Current pixel line, 0..479 |
| de_i | input | 1 | Display enable, high in the active area |
| pattern_i | input | 1 | High selects colour bars instead of text |
| rgb_o | output | 3 | Registered {red, green, blue} pixel |

## Verification
The assertions check on every cycle that the output is black one edge after display enable is low. They also check that pattern mode outputs the x bits, that text mode never gives a mixed colour, and that the enables follow the 6/0 slice phases. They further check that the glyph byte changes only after a load strobe, and that every text address issued is inside the page. The glyph contents can only be shown by the bench's scenarios: the row*40+col addressing, the half-row selection, the bit order, and the prefetch across a line end and the 479-to-0 wrap. Each of these is compared pixel by pixel against values computed from the page and font functions.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int CELL_LG  = 4;
  localparam int SLICE_LG = 3;
  localparam int CODE_W   = 7;

  // Fixed page content: printable codes spread over the page.
  function automatic logic [CODE_W-1:0] text_code_fn(int unsigned a);
    return CODE_W'(32 + ((a * 7 + a / 40) % 95));
  endfunction

  // Fixed font content: one byte per (code, glyph row, half).
  function automatic logic [7:0] glyph_byte_fn(int unsigned g);
    int unsigned v;
    v = g * 73 + (g >> 5) * 29 + 11;
    return 8'(v ^ (v >> 8));
  endfunction
endpackage

// File: rtl/txr_cell_fetch.sv
module txr_cell_fetch #(
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int XW   = 10,
  parameter int YW   = 10,
  parameter int AW   = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  output logic          txt_rd_o,
  output logic [AW-1:0] txt_addr_o,
  output logic          gly_ld_o,
  output logic [3:0]    grow_o,
  output logic          half_o
);
  import txr_pkg::*;

  localparam int SW = XW - SLICE_LG;            // slice index width
  localparam int CW = XW - CELL_LG;             // column width
  localparam int RW = YW - CELL_LG;             // row width
  localparam logic [SW:0]   SLICE_LIM = (SW+1)'(COLS * 2);
  localparam logic [YW-1:0] Y_LAST    = YW'(ROWS * 16 - 1);

  logic [2:0]    phase;
  logic [SW:0]   sl_inc;
  logic          wrap;
  logic [SW-1:0] nsl;
  logic [YW-1:0] ny;
  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [AW-1:0] row_w, col_w;
  logic          mem_en_q;
  logic [3:0]    grow_q;
  logic          half_q;

  assign phase  = x_i[2:0];
  assign sl_inc = {1'b0, x_i[XW-1:SLICE_LG]} + (SW+1)'(1);
  assign wrap   = sl_inc >= SLICE_LIM;
  assign nsl    = wrap ? '0 : sl_inc[SW-1:0];
  assign ny     = !wrap ? y_i : (y_i == Y_LAST) ? '0 : y_i + YW'(1);
  assign col    = nsl[SW-1:1];
  assign row    = ny[YW-1:CELL_LG];
  assign row_w  = AW'(row);
  assign col_w  = AW'(col);

  generate
    if (COLS == 40) begin : g_addr_shift
      assign txt_addr_o = (row_w << 5) + (row_w << 3) + col_w;
    end else begin : g_addr_mul
      assign txt_addr_o = AW'(row_w * AW'(COLS)) + col_w;
    end
  endgenerate

  assign txt_rd_o = (phase == 3'd6);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_en_q <= 1'b0;
      grow_q   <= '0;
      half_q   <= 1'b0;
    end else if (phase == 3'd6) begin
      mem_en_q <= 1'b1;
      grow_q   <= ny[CELL_LG-1:0];
      half_q   <= nsl[0];
    end else if (phase == 3'd0) begin
      mem_en_q <= 1'b0;
    end
  end

  assign gly_ld_o = mem_en_q && (phase == 3'd7);
  assign grow_o   = grow_q;
  assign half_o   = half_q;

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_en_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(phase == 3'd6) |-> mem_en_q)
    else $error("enable not set after phase 6");

  assert_en_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(phase == 3'd0) |-> !mem_en_q)
    else $error("enable not released after phase 0");
endmodule

// File: rtl/txr_text_rom.sv
module txr_text_rom #(
  parameter int AW    = 11,
  parameter int CELLS = 1200
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_i,
  input  logic [AW-1:0]              addr_i,
  output logic [txr_pkg::CODE_W-1:0] code_o
);
  import txr_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_o <= '0;
    else if (rd_i) code_o <= text_code_fn(int'(addr_i));
  end

  assert_addr_in_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> int'(addr_i) < CELLS)
    else $error("text address outside page");
endmodule

// File: rtl/txr_glyph_rom.sv
module txr_glyph_rom (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ld_i,
  input  logic [txr_pkg::CODE_W-1:0] code_i,
  input  logic [3:0]                 grow_i,
  input  logic                       half_i,
  output logic [7:0]                 byte_o
);
  import txr_pkg::*;

  // code*32 + grow*2 + half
  logic [CODE_W+4:0] gaddr;
  assign gaddr = {code_i, grow_i, half_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   byte_o <= '0;
    else if (ld_i) byte_o <= glyph_byte_fn(int'(gaddr));
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_byte_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(ld_i) |-> $stable(byte_o))
    else $error("glyph byte changed without load");
endmodule

// File: rtl/txr_pixel_out.sv
module txr_pixel_out (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] phase_i,
  input  logic [2:0] bar_i,
  input  logic       de_i,
  input  logic       pat_i,
  input  logic [7:0] byte_i,
  output logic [2:0] rgb_o
);
  logic       mono;
  logic [2:0] rgb_d;

  assign mono = byte_i[3'd7 - phase_i];

  always_comb begin
    if (!de_i)      rgb_d = 3'b000;
    else if (pat_i) rgb_d = bar_i;
    else            rgb_d = {3{mono}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_o <= 3'b000;
    else         rgb_o <= rgb_d;
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  assert_blank_black_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(de_i) |-> rgb_o == 3'b000)
    else $error("colour during blanking");

  assert_bars_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(de_i && pat_i) |-> rgb_o == $past(bar_i))
    else $error("pattern colour mismatch");

  assert_mono_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(de_i && !pat_i) |-> (rgb_o == 3'b000 || rgb_o == 3'b111))
    else $error("text pixel not monochrome");
endmodule

// File: rtl/text_pixel_renderer.sv
module text_pixel_renderer #(
  parameter int COLS = 40,
  parameter int ROWS = 30,
  parameter int XW   = 10,
  parameter int YW   = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] pix_x_i,
  input  logic [YW-1:0] pix_y_i,
  input  logic          de_i,
  input  logic          pattern_i,
  output logic [2:0]    rgb_o
);
  import txr_pkg::*;

  localparam int CELLS = COLS * ROWS;
  localparam int AW    = $clog2(CELLS);

  logic              txt_rd;
  logic [AW-1:0]     txt_addr;
  logic              gly_ld;
  logic [3:0]        grow;
  logic              half;
  logic [CODE_W-1:0] code;
  logic [7:0]        gbyte;

  txr_cell_fetch #(.COLS(COLS), .ROWS(ROWS), .XW(XW), .YW(YW), .AW(AW)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .x_i        (pix_x_i),
    .y_i        (pix_y_i),
    .txt_rd_o   (txt_rd),
    .txt_addr_o (txt_addr),
    .gly_ld_o   (gly_ld),
    .grow_o     (grow),
    .half_o     (half)
  );

  txr_text_rom #(.AW(AW), .CELLS(CELLS)) u_text (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (txt_rd),
    .addr_i (txt_addr),
    .code_o (code)
  );

  txr_glyph_rom u_glyph (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (gly_ld),
    .code_i (code),
    .grow_i (grow),
    .half_i (half),
    .byte_o (gbyte)
  );

  txr_pixel_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (pix_x_i[2:0]),
    .bar_i   (pix_x_i[7:5]),
    .de_i    (de_i),
    .pat_i   (pattern_i),
    .byte_i  (gbyte),
    .rgb_o   (rgb_o)
  );
endmodule

// File: tb/text_pixel_renderer_test.sv
`timescale 1ns/1ps
module text_pixel_renderer_test;
  import txr_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] px = '0;
  logic [9:0] py = '0;
  logic       de = 1'b0;
  logic       pat = 1'b0;
  logic [2:0] rgb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [2:0] exp;
    bit         chk;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  text_pixel_renderer uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_x_i(px), .pix_y_i(py),
    .de_i(de), .pattern_i(pat), .rgb_o(rgb)
  );

  // Expected pixel from the page/font content and the requirements.
  function automatic logic [2:0] model(int x, int y, bit d, bit p);
    int unsigned code, gaddr;
    logic [7:0]  b;
    if (!d) return 3'b000;
    if (p)  return 3'(x >> 5);
    code  = text_code_fn((y / 16) * 40 + (x / 16));
    gaddr = code * 32 + (y % 16) * 2 + ((x / 8) % 2);
    b     = glyph_byte_fn(gaddr);
    return {3{b[7 - (x % 8)]}};
  endfunction

  task automatic drive(int x, int y, bit d, bit p, bit chk, logic [2:0] exp, string tag);
    item_t it;
    @(negedge clk);
    px = 10'(x); py = 10'(y); de = d; pat = p;
    it.exp = exp; it.chk = chk; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic run_line(int y, bit d, bit p, string tag);
    for (int x = 0; x < 640; x++) drive(x, y, d, p, 1'b1, model(x, y, d, p), tag);
  endtask

  // Tail of the previous line so the first slice of line y is prefetched.
  task automatic lead_in(int y);
    int prev;
    prev = (y == 0) ? 479 : y - 1;
    for (int x = 632; x < 640; x++) drive(x, prev, 1'b0, 1'b0, 1'b0, 3'b000, "");
  endtask

  // Scoreboard monitor: one result per edge, for the inputs driven before it.
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      if (it.chk) begin
        checks++;
        if (rgb !== it.exp) begin
          fails++;
          $display("FAIL %s: rgb_o actual %b expected %b", it.tag, rgb, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired, all requirements: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    de = 1'b1; px = 10'd3;
    repeat (3) @(negedge clk);
    checks++;
    if (rgb !== 3'b000) begin
      fails++;
      $display("FAIL R1: rgb_o in reset actual %b expected 000", rgb);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1: no fetch has completed yet, so the first slice is black
    for (int x = 0; x < 8; x++) drive(x, 0, 1'b1, 1'b0, 1'b1, 3'b000, "R1 cleared byte");

    // R2 R3 R4 R6 R7: full text lines after a lead-in
    lead_in(0);
    run_line(0, 1'b1, 1'b0, "R2 R3 R4 R6 R7 line0");
    lead_in(37);
    run_line(37, 1'b1, 1'b0, "R2 R3 R4 R7 line37");
    // R5: back-to-back lines, prefetch crosses the line end
    lead_in(15);
    run_line(15, 1'b1, 1'b0, "R3 R4 line15");
    run_line(16, 1'b1, 1'b0, "R5 line16 after line15");
    // R5: last line then wrap to line 0
    lead_in(479);
    run_line(479, 1'b1, 1'b0, "R2 R3 line479");
    run_line(0, 1'b1, 1'b0, "R5 wrap to line0");
    // R8: colour bars
    lead_in(100);
    run_line(100, 1'b1, 1'b1, "R8 bars");
    // R9: blanking ignores pattern and glyphs; fetch keeps running
    lead_in(200);
    for (int x = 0; x < 640; x++)
      drive(x, 200, 1'b0, x[4], 1'b1, 3'b000, "R9 blank line");
    run_line(201, 1'b1, 1'b0, "R9 R5 line after blank");
    // R8 R9: mixed enable and pattern within one line
    lead_in(300);
    for (int x = 0; x < 640; x++) begin
      bit d, p;
      d = (x % 3) != 0;
      p = x >= 320;
      drive(x, 300, d, p, 1'b1, model(x, 300, d, p), "R8 R9 R6 mixed");
    end

    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule